// File: doc/BRIEF.md
# Dual-Counter PWM Timer

The block holds two 32-bit counters behind a small word-addressed register port. Each counter has a control word, a load value and a live count. Either counter can run on its own as a pulse generator: it counts up or down from its load value and gives a one-clock pulse each time it reaches its terminal count. With auto-reload set it restarts from the load value and keeps running. Without auto-reload it stops and clears its own enable.

When both counters are armed for PWM, counter 0 sets the period and counter 1 sets the high time of a single registered output. The output rises in the clock after counter 0 reloads. It falls when counter 1 reaches its terminal count. Counter 1 restarts from its load value at every counter-0 reload. An enable-all bit starts both counters in the same clock, so they never run skewed. Software may rewrite the load values while PWM runs, and each counter picks up its new value at its next reload.

Top module: `dual_pwm_timer`

## Requirements
- R1: After reset every register reads 0, and `pwm_out` and both `gen_out` bits are low.
- R2: Register words are decoded from byte address bits [4:2]: 0x00 control 0, 0x04 load 0, 0x08 count 0, 0x10 control 1, 0x14 load 1, 0x18 count 1; any other address reads 0. Control bits are: 0 count down, 1 capture select, 2 pulse-output enable, 4 auto-reload, 5 load, 7 enable, 9 PWM, 10 enable-all (always reads 0), 11 chain. Writes to the count words are ignored.
- R3: While a counter's load bit is set, its count copies its load value every clock and does not advance, even if enabled.
- R4: An enabled counter decrements by one per clock with bit 0 set and increments by one with bit 0 clear. The terminal count is 0 when counting down and all-ones when counting up. A counter with enable clear holds its count.
- R5: A counter without auto-reload that reaches its terminal count stays there and clears its own enable bit.
- R6: With auto-reload, a counter at its terminal count reloads from its load value on the next clock, giving a period of L+1 clocks when counting down and 2^32-L clocks when counting up. `gen_out[i]` pulses high for one clock, one clock after each terminal count, only when pulse-output enable is set and both PWM and capture select are clear.
- R7: Writing a control word with bit 10 set sets the enable bit of both counters in the same clock.
- R8: PWM runs only while both control words have auto-reload, enable, pulse-output enable and PWM set and load clear, and control 0 has chain clear. Otherwise `pwm_out` is low.
- R9: In PWM with load values P (counter 0) and D (counter 1), counting down, `pwm_out` repeats every P+1 clocks and is high for min(D+1, P) consecutive clocks of each period. Up counting uses the bitwise complements of P and D in place of P and D.
- R10: `pwm_out` is low for at least one clock in every period; when D >= P it is low for exactly one.
- R11: Load values written during PWM take effect at each counter's next reload, without stopping the output.
- R12: Writing 0 to both control words stops both counters and drives `pwm_out` low, and it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 5 | Byte address of the register word |
| wr_en | input | 1 | Write strobe, one word per clock |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 1 | Registered PWM output |
| gen_out | output | 2 | Per-counter terminal-count pulses |

## Verification
A wrong count or a wrong reload shows within one period as a wrong gap between pulses on `gen_out` or `pwm_out`. The count words on the read port show it on the very next clock. An error in the PWM arming logic shows as a stuck-low or a free-running output in the first period after enable-all. A bad duty cap shows as an output that never falls once the duty value reaches the period value. The bench measures whole high and low stretches, so an off-by-one in either counter changes a measured width by exactly one clock.

// File: rtl/pwmtmr_pkg.sv
package pwmtmr_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned ADDR_W = 5;

  localparam int unsigned B_DOWN = 0;
  localparam int unsigned B_CAPT = 1;
  localparam int unsigned B_GEN  = 2;
  localparam int unsigned B_ARL  = 4;
  localparam int unsigned B_LOAD = 5;
  localparam int unsigned B_EN   = 7;
  localparam int unsigned B_PWM  = 9;
  localparam int unsigned B_ALL  = 10;
  localparam int unsigned B_CHN  = 11;

  // word index = addr[4:2]
  localparam logic [2:0] W_CTL0 = 3'd0;
  localparam logic [2:0] W_LD0  = 3'd1;
  localparam logic [2:0] W_CNT0 = 3'd2;
  localparam logic [2:0] W_CTL1 = 3'd4;
  localparam logic [2:0] W_LD1  = 3'd5;
  localparam logic [2:0] W_CNT1 = 3'd6;

  typedef struct packed {
    logic chn;
    logic pwm;
    logic en;
    logic load;
    logic arl;
    logic gen;
    logic capt;
    logic down;
  } tctl_t;

  function automatic tctl_t ctl_from_word(input logic [DW-1:0] w);
    tctl_t c;
    c.chn  = w[B_CHN];
    c.pwm  = w[B_PWM];
    c.en   = w[B_EN] | w[B_ALL];
    c.load = w[B_LOAD];
    c.arl  = w[B_ARL];
    c.gen  = w[B_GEN];
    c.capt = w[B_CAPT];
    c.down = w[B_DOWN];
    return c;
  endfunction

  function automatic logic [DW-1:0] ctl_to_word(input tctl_t c);
    logic [DW-1:0] w;
    w         = '0;
    w[B_CHN]  = c.chn;
    w[B_PWM]  = c.pwm;
    w[B_EN]   = c.en;
    w[B_LOAD] = c.load;
    w[B_ARL]  = c.arl;
    w[B_GEN]  = c.gen;
    w[B_CAPT] = c.capt;
    w[B_DOWN] = c.down;
    return w;
  endfunction
endpackage

// File: rtl/pwmtmr_rst_sync.sv
module pwmtmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/pwmtmr_counter.sv
module pwmtmr_counter
  import pwmtmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          ld_we,
  input  logic [DW-1:0] wdata,
  input  logic          en_all,
  input  logic          restart,
  output tctl_t         ctl,
  output logic [DW-1:0] ld,
  output logic [DW-1:0] cnt,
  output logic          tc_evt,
  output logic          tc_next
);
  tctl_t         ctl_d;
  logic [DW-1:0] ld_d;
  logic [DW-1:0] cnt_d;
  logic [DW-1:0] term;
  logic          at_tc;

  always_comb begin
    term   = ctl.down ? '0 : '1;
    at_tc  = (cnt == term);
    tc_evt = ctl.en && !ctl.load && at_tc;

    ctl_d = ctl;
    if (ctl_we)                    ctl_d = ctl_from_word(wdata);
    else if (en_all)               ctl_d.en = 1'b1;
    else if (tc_evt && !ctl.arl)   ctl_d.en = 1'b0;

    ld_d = ld_we ? wdata : ld;

    cnt_d = cnt;
    if (ctl.load || restart)       cnt_d = ld;
    else if (ctl.en) begin
      if (at_tc)                   cnt_d = ctl.arl ? ld : cnt;
      else if (ctl.down)           cnt_d = cnt - 1'b1;
      else                         cnt_d = cnt + 1'b1;
    end

    tc_next = (cnt_d == (ctl_d.down ? '0 : '1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      ld  <= '0;
      cnt <= '0;
    end else begin
      ctl <= ctl_d;
      if (ld_we) ld <= ld_d;
      cnt <= cnt_d;
    end
  end

  p_load_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |=> (cnt == $past(ld)));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.en && !ctl.load && !restart) |=> $stable(cnt));

  p_stop_clears_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_evt && !ctl.arl && !ctl_we && !en_all) |=> !ctl.en);

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_evt && ctl.arl && !restart) |=> (cnt == $past(ld)));
endmodule

// File: rtl/pwmtmr_wave.sv
module pwmtmr_wave #(
  parameter int unsigned NCNT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            r0,
  input  logic            t1,
  input  logic            tc0_next,
  input  logic [NCNT-1:0] gen_req,
  output logic            pwm_out,
  output logic [NCNT-1:0] gen_out
);
  logic pwm_q;
  logic pwm_d;

  always_comb begin
    if (!active || tc0_next) pwm_d = 1'b0;
    else if (r0)             pwm_d = 1'b1;
    else if (t1)             pwm_d = 1'b0;
    else                     pwm_d = pwm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm_out = pwm_q;

  for (genvar i = 0; i < NCNT; i++) begin : g_pulse
    logic gq;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gq <= 1'b0;
      else        gq <= gen_req[i];
    end
    assign gen_out[i] = gq;
  end

  p_off_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !pwm_q);

  p_low_at_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && r0) |-> !pwm_q);

  p_rise_after_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && r0 && !tc0_next) |=> pwm_q);
endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
  import pwmtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  output logic              pwm_out,
  output logic [1:0]        gen_out
);
  localparam int unsigned NCNT = 2;

  logic              rst_q;
  logic [2:0]        widx;
  logic              en_all;
  logic              active;
  logic [NCNT-1:0]   ctl_we, ld_we, restart, tc_evt, tc_next, gen_req;
  tctl_t             ctl  [NCNT];
  logic [DW-1:0]     ld   [NCNT];
  logic [DW-1:0]     cnt  [NCNT];
  logic              unused_addr_bits;

  pwmtmr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  assign widx             = addr[4:2];
  assign unused_addr_bits = ^addr[1:0];
  assign en_all = wr_en && (widx == W_CTL0 || widx == W_CTL1) && wr_data[B_ALL];

  assign active = ctl[0].arl && ctl[0].en && ctl[0].gen && ctl[0].pwm &&
                  !ctl[0].load && !ctl[0].chn &&
                  ctl[1].arl && ctl[1].en && ctl[1].gen && ctl[1].pwm &&
                  !ctl[1].load;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    localparam logic [2:0] CTL_W = (i == 0) ? W_CTL0 : W_CTL1;
    localparam logic [2:0] LD_W  = (i == 0) ? W_LD0  : W_LD1;

    assign ctl_we[i]  = wr_en && (widx == CTL_W);
    assign ld_we[i]   = wr_en && (widx == LD_W);
    assign restart[i] = (i == 1) ? (active && tc_evt[0]) : 1'b0;
    assign gen_req[i] = tc_evt[i] && ctl[i].gen && !ctl[i].pwm && !ctl[i].capt;

    pwmtmr_counter u_cnt (
      .clk    (clk),
      .rst_n  (rst_q),
      .ctl_we (ctl_we[i]),
      .ld_we  (ld_we[i]),
      .wdata  (wr_data),
      .en_all (en_all),
      .restart(restart[i]),
      .ctl    (ctl[i]),
      .ld     (ld[i]),
      .cnt    (cnt[i]),
      .tc_evt (tc_evt[i]),
      .tc_next(tc_next[i])
    );
  end

  pwmtmr_wave #(.NCNT(NCNT)) u_wave (
    .clk     (clk),
    .rst_n   (rst_q),
    .active  (active),
    .r0      (tc_evt[0]),
    .t1      (tc_evt[1]),
    .tc0_next(tc_next[0]),
    .gen_req (gen_req),
    .pwm_out (pwm_out),
    .gen_out (gen_out)
  );

  always_comb begin
    case (widx)
      W_CTL0:  rd_data = ctl_to_word(ctl[0]);
      W_LD0:   rd_data = ld[0];
      W_CNT0:  rd_data = cnt[0];
      W_CTL1:  rd_data = ctl_to_word(ctl[1]);
      W_LD1:   rd_data = ld[1];
      W_CNT1:  rd_data = cnt[1];
      default: rd_data = '0;
    endcase
  end

  p_enall_both_r7: assert property (@(posedge clk) disable iff (!rst_q)
    en_all |=> (ctl[0].en && ctl[1].en));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_q |-> (!pwm_out && gen_out == 2'b00));
endmodule

// File: tb/dual_pwm_timer_test.sv
module dual_pwm_timer_test;
  localparam time TCLK = 10ns;

  localparam logic [4:0] A_CTL0 = 5'h00, A_LD0 = 5'h04, A_CNT0 = 5'h08;
  localparam logic [4:0] A_CTL1 = 5'h10, A_LD1 = 5'h14, A_CNT1 = 5'h18;
  localparam logic [31:0] C_DOWN = 32'h1,  C_GEN = 32'h4,   C_ARL = 32'h10;
  localparam logic [31:0] C_LOAD = 32'h20, C_EN  = 32'h80,  C_PWM = 32'h200;
  localparam logic [31:0] C_ALL  = 32'h400, C_CHN = 32'h800;
  localparam logic [31:0] C_SET  = C_GEN | C_ARL | C_PWM | C_EN;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;
  logic [1:0]  gen_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  dual_pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out), .gen_out(gen_out)
  );

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rd_data;
  endtask

  function automatic logic [32:0] span(input logic [31:0] l, input bit up);
    return up ? {1'b0, ~l} : {1'b0, l};
  endfunction

  function automatic int exp_per(input logic [31:0] p, input bit up);
    return int'(span(p, up)) + 1;
  endfunction

  function automatic int exp_high(input logic [31:0] p, input logic [31:0] d, input bit up);
    logic [32:0] a, b;
    a = span(p, up);
    b = span(d, up) + 33'd1;
    return (b < a) ? int'(b) : int'(a);
  endfunction

  task automatic pwm_start(input logic [31:0] p, input logic [31:0] d, input bit up);
    logic [31:0] dir;
    dir = up ? 32'h0 : C_DOWN;
    wr(A_CTL0, 32'h0);
    wr(A_CTL1, 32'h0);
    wr(A_LD0, p);
    wr(A_LD1, d);
    wr(A_CTL0, C_LOAD);
    wr(A_CTL1, C_LOAD);
    wr(A_CTL0, (C_SET & ~C_EN) | dir);
    wr(A_CTL1, C_SET | C_ALL | dir);
  endtask

  task automatic pwm_measure(output int hi, output int lo, output int gp);
    int w;
    hi = 0; lo = 0; gp = 0; w = 0;
    @(negedge clk);
    while (pwm_out !== 1'b0 && w < 400) begin @(negedge clk); w++; end
    while (pwm_out !== 1'b1 && w < 400) begin @(negedge clk); w++; end
    while (pwm_out === 1'b1 && w < 400) begin
      hi++; if (gen_out != 2'b00) gp++; @(negedge clk); w++;
    end
    while (pwm_out === 1'b0 && w < 400) begin
      lo++; if (gen_out != 2'b00) gp++; @(negedge clk); w++;
    end
  endtask

  task automatic gen_interval(input int idx, output int n);
    int w;
    w = 0; n = 0;
    @(negedge clk);
    while (gen_out[idx] !== 1'b1 && w < 300) begin @(negedge clk); w++; end
    @(negedge clk);
    n = 1;
    while (gen_out[idx] !== 1'b1 && n < 300) begin @(negedge clk); n++; end
  endtask

  task automatic pwm_case(input string req, input logic [31:0] p, input logic [31:0] d, input bit up);
    int hi, lo, gp;
    pwm_start(p, d, up);
    pwm_measure(hi, lo, gp);
    chk({req, " high"}, hi, exp_high(p, d, up));
    chk({req, " period"}, hi + lo, exp_per(p, up));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, v2;
    int n, hi, lo, gp, cnt_ones;
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_CTL0, v); chk("R1 ctl0", v, 32'h0);
    rd(A_LD0, v);  chk("R1 ld0", v, 32'h0);
    rd(A_CNT1, v); chk("R1 cnt1", v, 32'h0);
    rd(A_CTL1, v); chk("R1 ctl1", v, 32'h0);
    chk("R1 outputs", {29'h0, pwm_out, gen_out}, 32'h0);

    // R2 map, read-only counts, enable-all reads 0, hole reads 0
    wr(A_LD0, 32'hA5A5_5A5A);
    rd(A_LD0, v); chk("R2 ld0 readback", v, 32'hA5A5_5A5A);
    wr(A_CTL0, 32'hFFFF_FFFF);
    rd(A_CTL0, v); chk("R2 ctl0 bits", v, 32'h0000_0AB7);
    wr(A_CNT0, 32'h1234_5678);
    rd(A_CNT0, v); chk("R2 cnt0 write ignored", v, 32'hA5A5_5A5A);
    rd(5'h0C, v);  chk("R2 hole", v, 32'h0);
    wr(A_CTL0, 32'h0);

    // R3 load bit holds count at the load value even when enabled
    wr(A_LD0, 32'd3);
    wr(A_CTL0, C_LOAD | C_EN | C_DOWN);
    rd(A_CNT0, v); chk("R3 copy", v, 32'd3);
    repeat (3) @(negedge clk);
    rd(A_CNT0, v); chk("R3 no count", v, 32'd3);

    // R4 down count, R5 stop without auto-reload, single pulse
    wr(A_CTL0, C_EN | C_DOWN | C_GEN);
    rd(A_CNT0, v); chk("R4 down 2", v, 32'd2);
    rd(A_CNT0, v); chk("R4 down 1", v, 32'd1);
    rd(A_CNT0, v); chk("R4 down 0", v, 32'd0);
    cnt_ones = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); #1; if (gen_out[0] === 1'b1) cnt_ones++;
    end
    chk("R5 single pulse", cnt_ones, 32'd1);
    rd(A_CTL0, v); chk("R5 enable cleared", v & C_EN, 32'h0);
    rd(A_CNT0, v); chk("R5 held at terminal", v, 32'd0);

    // R4 up count
    wr(A_LD0, 32'd100);
    wr(A_CTL0, C_LOAD);
    wr(A_CTL0, C_EN);
    rd(A_CNT0, v); chk("R4 up 101", v, 32'd101);
    rd(A_CNT0, v); chk("R4 up 102", v, 32'd102);
    wr(A_CTL0, 32'h0);
    rd(A_CNT0, v);
    rd(A_CNT0, v2); chk("R4 disabled holds", v2, v);

    // R6 auto-reload periods
    wr(A_LD1, 32'd4);
    wr(A_CTL1, C_LOAD);
    wr(A_CTL1, C_EN | C_DOWN | C_ARL | C_GEN);
    gen_interval(1, n); chk("R6 down period", n, 32'd5);
    wr(A_CTL1, 32'h0);
    wr(A_LD0, 32'hFFFF_FFFC);
    wr(A_CTL0, C_LOAD);
    wr(A_CTL0, C_EN | C_ARL | C_GEN);
    gen_interval(0, n); chk("R6 up period", n, 32'd4);
    wr(A_CTL0, 32'h0);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] l;
      l = 32'd1 + ($urandom % 30);
      wr(A_LD0, l);
      wr(A_CTL0, C_LOAD);
      wr(A_CTL0, C_EN | C_DOWN | C_ARL | C_GEN);
      gen_interval(0, n); chk("R6 random period", n, l + 32'd1);
      wr(A_CTL0, 32'h0);
    end
    wr(A_CTL0, C_EN | C_DOWN | C_ARL | C_GEN | 32'h2);
    cnt_ones = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); #1; if (gen_out[0] === 1'b1) cnt_ones++;
    end
    chk("R6 capture select blocks pulses", cnt_ones, 32'd0);
    wr(A_CTL0, 32'h0);

    // R7 enable-all from control 1 starts both together
    wr(A_LD0, 32'd20);
    wr(A_LD1, 32'd20);
    wr(A_CTL0, C_LOAD);
    wr(A_CTL1, C_LOAD);
    wr(A_CTL0, C_DOWN);
    wr(A_CTL1, C_DOWN | C_ALL);
    rd(A_CTL0, v); chk("R7 ctl0 enabled", v & (C_EN | C_ALL), C_EN);
    rd(A_CTL1, v); chk("R7 ctl1 enabled", v & (C_EN | C_ALL), C_EN);
    rd(A_CNT0, v);
    rd(A_CNT1, v2); chk("R7 no skew", v2, v - 32'd1);

    // R9 / R10 directed
    pwm_case("R9 P10 D3", 32'd10, 32'd3, 1'b0);
    pwm_case("R9 P1 D0", 32'd1, 32'd0, 1'b0);
    pwm_case("R10 D equals P", 32'd8, 32'd8, 1'b0);
    pwm_case("R10 D above P", 32'd6, 32'd30, 1'b0);
    pwm_case("R9 up", 32'hFFFF_FFF5, 32'hFFFF_FFFB, 1'b1);
    pwm_measure(hi, lo, gp);
    chk("R6 no pulses in PWM", gp, 32'd0);

    // R9 random
    for (int k = 0; k < 8; k++) begin
      logic [31:0] p, d;
      bit up;
      p  = 32'd2 + ($urandom % 30);
      d  = $urandom % 40;
      up = ($urandom % 2) == 1;
      if (up) pwm_case("R9 random up", ~p, ~d, 1'b1);
      else    pwm_case("R9 random down", p, d, 1'b0);
    end

    // R11 load update while running
    pwm_start(32'd10, 32'd3, 1'b0);
    pwm_measure(hi, lo, gp);
    wr(A_LD0, 32'd6);
    wr(A_LD1, 32'd8);
    pwm_measure(hi, lo, gp);
    pwm_measure(hi, lo, gp);
    chk("R11 new high", hi, 32'd6);
    chk("R11 new period", hi + lo, 32'd7);

    // R8 blocking conditions
    pwm_start(32'd5, 32'd2, 1'b0);
    wr(A_CTL0, C_SET | C_CHN | C_DOWN);
    cnt_ones = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); #1; if (pwm_out === 1'b1) cnt_ones++;
    end
    chk("R8 chain blocks", cnt_ones, 32'd0);
    wr(A_CTL0, C_SET | C_DOWN);
    wr(A_CTL1, C_SET | C_LOAD | C_DOWN);
    cnt_ones = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); #1; if (pwm_out === 1'b1) cnt_ones++;
    end
    chk("R8 load blocks", cnt_ones, 32'd0);
    wr(A_CTL1, (C_SET & ~C_EN) | C_DOWN);
    cnt_ones = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); #1; if (pwm_out === 1'b1) cnt_ones++;
    end
    chk("R8 one counter only", cnt_ones, 32'd0);

    // R12 stop
    pwm_start(32'd5, 32'd2, 1'b0);
    n = 0;
    while (pwm_out !== 1'b1 && n < 100) begin @(negedge clk); n++; end
    wr(A_CTL0, 32'h0);
    wr(A_CTL1, 32'h0);
    chk("R12 low after stop", {31'h0, pwm_out}, 32'h0);
    cnt_ones = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #1; if (pwm_out === 1'b1) cnt_ones++;
    end
    chk("R12 stays low", cnt_ones, 32'd0);
    rd(A_CNT0, v);
    rd(A_CNT0, v2); chk("R12 counter stopped", v2, v);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule